// File: doc/BRIEF.md
# Byte substitution layer built from 4-bit mini-boxes

This block performs the nonlinear step of a byte-oriented block cipher. Every byte of a wide state goes through the same 8-bit substitution. The substitution is not stored as a 256-entry table. Each byte is instead passed through a three-stage network of two 4-bit lookups, P and Q, with fixed bit crossings between the stages. Each mini-box is its own inverse, and so is the whole byte map. Applying the layer twice therefore returns the original state, so one circuit serves both directions of the cipher.

The datapath has no control at all. Every lane is evaluated in every cycle, whatever the data. Nothing exits early and nothing is gated by data, so the timing does not depend on the operands. A parameter selects either a registered output stage with a synchronous reset, or a purely combinational path.

Top module: `snx_sublayer`

## Requirements
- R1: With the registered stage enabled, byte lane k of `dout` equals S(byte lane k of `din`) as sampled at the previous rising clock edge, for every lane k. Lanes do not interact.
- R2: Mini-box Q maps nibbles 0..F (hex) to 9,E,5,6,A,2,3,C,F,0,4,D,7,B,1,8.
- R3: Mini-box P maps nibbles 0..F (hex) to 3,F,E,0,5,4,B,C,D,A,9,6,7,8,2,1.
- R4: S runs three stages. In stage one, bits [7:4] go through P and bits [3:0] go through Q. In stage two, bits [7:4] go through Q and bits [3:0] go through P. In stage three, bits [7:4] go through P and bits [3:0] go through Q. After stages one and two, bits [5:4] and bits [3:2] of the byte exchange places. No exchange follows stage three.
- R5: S(S(a)) = a for all 256 byte values, so feeding `dout` back into `din` returns the earlier input one cycle later.
- R6: S(0x00)=0xBA, S(0x01)=0x54 and S(0x02)=0x2F.
- R7: When `rst` is high at a rising edge, `dout` is all zeros after that edge, whatever `din` holds.
- R8: The output changes only as a result of `din` or `rst`. When `din` is held steady outside reset, `dout` stays steady, with no enable and no data-dependent stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| din | input | NBYTES*8 | State to substitute, byte lane k at bits [8k+7:8k] |
| dout | output | NBYTES*8 | Substituted state |

## Verification
Reset and a fresh data word can arrive at the same edge. The bench provokes this by driving a nonzero pattern together with `rst`, and also by asserting reset in the middle of a sweep. In both cases it expects all-zero output and not the substituted word. The substitution and the involution property also overlap. On the cycle after a byte pattern is applied, the bench feeds the registered result straight back as the next input. It judges both edges: the first result against the reference model, and the second against the original pattern.

// File: rtl/snx_pkg.sv
package snx_pkg;
  typedef enum logic {MB_P = 1'b0, MB_Q = 1'b1} mbox_e;

  function automatic logic [3:0] mini_p(input logic [3:0] x);
    logic [3:0] r;
    case (x)
      4'h0: r = 4'h3; 4'h1: r = 4'hF; 4'h2: r = 4'hE; 4'h3: r = 4'h0;
      4'h4: r = 4'h5; 4'h5: r = 4'h4; 4'h6: r = 4'hB; 4'h7: r = 4'hC;
      4'h8: r = 4'hD; 4'h9: r = 4'hA; 4'hA: r = 4'h9; 4'hB: r = 4'h6;
      4'hC: r = 4'h7; 4'hD: r = 4'h8; 4'hE: r = 4'h2; default: r = 4'h1;
    endcase
    return r;
  endfunction

  function automatic logic [3:0] mini_q(input logic [3:0] x);
    logic [3:0] r;
    case (x)
      4'h0: r = 4'h9; 4'h1: r = 4'hE; 4'h2: r = 4'h5; 4'h3: r = 4'h6;
      4'h4: r = 4'hA; 4'h5: r = 4'h2; 4'h6: r = 4'h3; 4'h7: r = 4'hC;
      4'h8: r = 4'hF; 4'h9: r = 4'h0; 4'hA: r = 4'h4; 4'hB: r = 4'hD;
      4'hC: r = 4'h7; 4'hD: r = 4'hB; 4'hE: r = 4'h1; default: r = 4'h8;
    endcase
    return r;
  endfunction

  // Exchange the two middle bit pairs across the nibble boundary.
  function automatic logic [7:0] cross_mid(input logic [7:0] b);
    return {b[7:6], b[3:2], b[5:4], b[1:0]};
  endfunction
endpackage

// File: rtl/snx_minibox.sv
module snx_minibox
  import snx_pkg::*;
#(
  parameter mbox_e KIND = MB_P
) (
  input  logic [3:0] x,
  output logic [3:0] y
);
  generate
    if (KIND == MB_P) begin : g_p
      assign y = mini_p(x);   // R3
    end else begin : g_q
      assign y = mini_q(x);   // R2
    end
  endgenerate
endmodule

// File: rtl/snx_sbox8.sv
module snx_sbox8
  import snx_pkg::*;
#(
  parameter int STAGES = 3
) (
  input  logic [7:0] a,
  output logic [7:0] y
);
  logic [7:0] st [STAGES+1];
  logic [7:0] mix [STAGES];

  assign st[0] = a;

  generate
    for (genvar l = 0; l < STAGES; l++) begin : g_stage
      localparam mbox_e HI_KIND = (l % 2 == 0) ? MB_P : MB_Q;
      localparam mbox_e LO_KIND = (l % 2 == 0) ? MB_Q : MB_P;

      snx_minibox #(.KIND(HI_KIND)) u_hi (.x(st[l][7:4]), .y(mix[l][7:4]));
      snx_minibox #(.KIND(LO_KIND)) u_lo (.x(st[l][3:0]), .y(mix[l][3:0]));

      if (l < STAGES - 1) begin : g_cross
        assign st[l+1] = cross_mid(mix[l]);   // R4
      end else begin : g_last
        assign st[l+1] = mix[l];
      end
    end
  endgenerate

  assign y = st[STAGES];
endmodule

// File: rtl/snx_sublayer.sv
module snx_sublayer #(
  parameter int NBYTES  = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NBYTES*8-1:0] din,
  output logic [NBYTES*8-1:0] dout
);
  localparam int W = NBYTES * 8;

  logic [W-1:0] sub;

  generate
    for (genvar k = 0; k < NBYTES; k++) begin : g_lane
      snx_sbox8 u_sb (.a(din[k*8 +: 8]), .y(sub[k*8 +: 8]));   // R1
    end

    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) dout <= '0;           // R7
        else     dout <= sub;
      end
    end else begin : g_comb
      assign dout = sub;
    end
  endgenerate
endmodule

// File: rtl/snx_sublayer_chk.sv
module snx_sublayer_chk #(
  parameter int NBYTES  = 16,
  parameter bit REG_OUT = 1'b1
) (
  input logic                clk,
  input logic                rst,
  input logic [NBYTES*8-1:0] din,
  input logic [NBYTES*8-1:0] dout
);
  logic [NBYTES*8-1:0] back;

  generate
    for (genvar k = 0; k < NBYTES; k++) begin : g_inv
      snx_sbox8 u_inv (.a(dout[k*8 +: 8]), .y(back[k*8 +: 8]));
    end

    if (REG_OUT) begin : g_props
      AST_RESET_ZERO: assert property (@(posedge clk) rst |=> dout == '0); // R7
      AST_INVOLUTION: assert property (@(posedge clk) disable iff (rst)
        !rst |=> back == $past(din)); // R5
      AST_ZERO_BYTE: assert property (@(posedge clk) disable iff (rst)
        din[7:0] == 8'h00 |=> dout[7:0] == 8'hBA); // R6
      AST_ONE_BYTE: assert property (@(posedge clk) disable iff (rst)
        din[7:0] == 8'h01 |=> dout[7:0] == 8'h54); // R6
      AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(din)) |=> $stable(dout)); // R8
    end
  endgenerate
endmodule

bind snx_sublayer snx_sublayer_chk #(.NBYTES(NBYTES), .REG_OUT(REG_OUT)) chk_i (
  .clk(clk), .rst(rst), .din(din), .dout(dout)
);

// File: tb/snx_sublayer_tb_top.sv
`timescale 1ns/1ps
module snx_sublayer_tb_top;
  localparam int NB = 16;
  localparam int W  = NB * 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_v = '0;
  bit           have_exp = 1'b0;
  string        exp_tag = "R7";
  bit           done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  snx_sublayer #(.NBYTES(NB), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .din(din), .dout(dout)
  );

  // Behavioural reference: lookup lists plus integer arithmetic.
  function automatic int tp(input int n);
    int t[16] = '{3,15,14,0,5,4,11,12,13,10,9,6,7,8,2,1};   // R3
    return t[n];
  endfunction
  function automatic int tq(input int n);
    int t[16] = '{9,14,5,6,10,2,3,12,15,0,4,13,7,11,1,8};   // R2
    return t[n];
  endfunction
  function automatic int swp(input int b);
    return (b & 'hC3) | ((b & 'h30) / 4) | ((b & 'h0C) * 4);
  endfunction
  function automatic logic [7:0] ref_s(input logic [7:0] v);   // R4
    int b = int'(v);
    b = swp(tp(b / 16) * 16 + tq(b % 16));
    b = swp(tq(b / 16) * 16 + tp(b % 16));
    b = tp(b / 16) * 16 + tq(b % 16);
    return 8'(b);
  endfunction
  function automatic logic [W-1:0] ref_all(input logic [W-1:0] d);
    logic [W-1:0] r;
    for (int k = 0; k < NB; k++) r[k*8 +: 8] = ref_s(d[k*8 +: 8]);
    return r;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Compare at the falling edge, then drive the next input.
  task automatic step(input string tag, input logic r, input logic [W-1:0] d);
    @(negedge clk);
    if (have_exp) check(exp_tag, dout, exp_v);
    rst = r;
    din = d;
    exp_v = r ? '0 : ref_all(d);
    exp_tag = tag;
    have_exp = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] pat;
    logic [W-1:0] keep;
    // Reset collides with nonzero data: R7
    step("R7", 1'b1, {NB{8'hA5}});
    step("R7", 1'b1, {NB{8'h3C}});
    @(negedge clk);
    check("R7", dout, '0);
    // Known values in lanes 0..2: R6
    step("R6", 1'b0, {{(NB-3){8'h77}}, 8'h02, 8'h01, 8'h00});
    @(posedge clk); #2;
    checks++;
    if (dout[23:0] !== 24'h2F54BA) begin
      errors++;
      $display("FAIL R6 act=%h exp=2f54ba", dout[23:0]);
    end
    // All byte values, each with its feedback pass: R1 R5
    for (int a = 0; a < 256; a++) begin
      for (int k = 0; k < NB; k++) pat[k*8 +: 8] = 8'(a + 37 * k);
      step("R1", 1'b0, pat);
      @(negedge clk);
      check("R1", dout, exp_v);
      keep = dout;
      din = keep;
      exp_v = pat;
      exp_tag = "R5";
    end
    // Held input keeps output steady: R8
    pat = {NB{8'h5E}};
    step("R8", 1'b0, pat);
    step("R8", 1'b0, pat);
    step("R8", 1'b0, pat);
    step("R8", 1'b0, pat);
    // Reset in the middle of a stream: R7
    step("R1", 1'b0, {NB{8'hC7}});
    step("R7", 1'b1, {NB{8'h91}});
    step("R1", 1'b0, {NB{8'h00}});
    step("R6", 1'b0, {NB{8'h01}});
    @(negedge clk);
    check(exp_tag, dout, exp_v);
    check("R6", dout, {NB{8'h54}});
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule